// File: doc/BRIEF.md
# Software Interrupt and Trap Cause Unit

This block holds the software-interrupt state of one hart for two privilege levels, supervisor and user, and turns it, together with synchronous exception strobes from the pipeline, into a single trap request with a 32-bit cause word. Software raises or withdraws a software interrupt only by writing a pending register through a CSR-style write port. A separate enable register gates each level, and a global interrupt-enable input gates both.

Each cycle the block picks one trap. Synchronous exceptions come first, and among them the lowest cause code wins. An environment call ranks below the fault strobes. Its code is 8 plus the current privilege mode. When no exception is present, an enabled and pending supervisor software interrupt wins over a user one. Bit 31 of the cause word marks an interrupt. Taking a trap never changes the pending bits.

Top module: `swi_trap_unit`

## Requirements
- R1: While reset is asserted and right after it, both the pending register and the enable register read as zero, and trap_valid_o is 0 when no exception strobe is raised.
- R2: A write with csr_wsel_i=0 loads the pending register. Bit 0 is the user pending bit and bit 1 is the supervisor pending bit. Writing 1 sets a bit and writing 0 clears it. A read with csr_rsel_i=0 returns those two bits at positions 0 and 1, and all other bits read as 0.
- R3: A write with csr_wsel_i=1 loads the enable register, with the same bit positions as R2. A read with csr_rsel_i=1 returns it, and all other bits read as 0.
- R4: With no exception raised, trap_valid_o=1 and trap_cause_o=32'h8000_0001 when supervisor pending, supervisor enable and gie_i are all 1.
- R5: With no exception and no supervisor interrupt taken, trap_valid_o=1 and trap_cause_o=32'h8000_0000 when user pending, user enable and gie_i are all 1. A supervisor interrupt that is taken overrides the user one.
- R6: A software interrupt is not signalled while its enable bit is 0 or gie_i is 0, even when its pending bit is set.
- R7: exc_i bit n raises a synchronous exception with cause n, for n in {0,1,2,3,5,7}. The lowest raised code wins, and bit 31 of the cause is 0. Bits 4 and 6 of exc_i have no effect.
- R8: ecall_i raises an exception with cause 8+priv_i. It loses to any fault strobe from R7.
- R9: Any exception from R7 or R8 takes priority over a software interrupt.
- R10: Taking a trap does not change the pending bits. Only a pending-register write changes them.
- R11: When a CSR write and a trap fall in the same cycle, the trap is judged on the register values from before the write. The written values govern from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wsel_i | input | 1 | Write target: 0 pending, 1 enable |
| csr_wdata_i | input | 32 | Write data |
| csr_rsel_i | input | 1 | Read source: 0 pending, 1 enable |
| csr_rdata_o | output | 32 | Read data |
| exc_i | input | 8 | Synchronous exception strobes, indexed by cause code |
| ecall_i | input | 1 | Environment call strobe |
| priv_i | input | 2 | Current privilege mode |
| gie_i | input | 1 | Global interrupt enable |
| trap_valid_o | output | 1 | Trap request |
| trap_cause_o | output | 32 | Cause word, bit 31 set for interrupts |

## Verification
Two things can fall in the same cycle. A CSR write can retire in the same cycle that a trap is judged, and an exception strobe can rise while a software interrupt is already enabled and pending. The bench forces both cases with directed steps: it clears the pending register while both interrupts are live, and it raises fault and ecall strobes over live interrupts. Random steps mix all inputs freely. A bench model that commits writes only after the clock edge predicts each outcome. The bench expects the old-value cause in the write cycle, the new state in the cycle after it, and the exception code whenever a strobe is up.

// File: rtl/swi_trap_pkg.sv
package swi_trap_pkg;
  localparam int XLEN       = 32;
  localparam int NUM_EXC    = 8;
  localparam int CODE_W     = 5;
  localparam int NUM_LVL    = 2;
  localparam int LVL_USR    = 0;
  localparam int LVL_SUP    = 1;
  localparam int ECALL_BASE = 8;
  // cause codes 4 and 6 are not fault strobes
  localparam logic [NUM_EXC-1:0] EXC_MASK = 8'hAF;

  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_EN   = 1'b1
  } csr_sel_e;
endpackage

// File: rtl/swi_csr_regs.sv
module swi_csr_regs
  import swi_trap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               wsel_i,
  input  logic [XLEN-1:0]    wdata_i,
  input  logic               rsel_i,
  output logic [NUM_LVL-1:0] pend_o,
  output logic [NUM_LVL-1:0] en_o,
  output logic [XLEN-1:0]    rdata_o
);
  logic [NUM_LVL-1:0] pend_q, en_q;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[l] <= 1'b0;
        en_q[l]   <= 1'b0;
      end else if (we_i) begin
        if (wsel_i == SEL_PEND) pend_q[l] <= wdata_i[l];
        else                    en_q[l]   <= wdata_i[l];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[NUM_LVL-1:0] = (rsel_i == SEL_EN) ? en_q : pend_q;
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/swi_exc_pick.sv
module swi_exc_pick
  import swi_trap_pkg::*;
(
  input  logic [NUM_EXC-1:0] exc_i,
  input  logic               ecall_i,
  input  logic [1:0]         priv_i,
  output logic               hit_o,
  output logic [CODE_W-1:0]  code_o
);
  logic [NUM_EXC-1:0] live;
  assign live = exc_i & EXC_MASK;

  always_comb begin
    hit_o  = 1'b0;
    code_o = '0;
    if (ecall_i) begin
      hit_o  = 1'b1;
      code_o = CODE_W'(ECALL_BASE) + CODE_W'(priv_i);
    end
    // descending scan leaves the lowest live code
    for (int i = NUM_EXC - 1; i >= 0; i--) begin
      if (live[i]) begin
        hit_o  = 1'b1;
        code_o = CODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/swi_trap_arb.sv
module swi_trap_arb
  import swi_trap_pkg::*;
(
  input  logic               exc_hit_i,
  input  logic [CODE_W-1:0]  exc_code_i,
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic [NUM_LVL-1:0] en_i,
  input  logic               gie_i,
  output logic               valid_o,
  output logic [XLEN-1:0]    cause_o
);
  logic [NUM_LVL-1:0] irq_live;
  assign irq_live = pend_i & en_i & {NUM_LVL{gie_i}};

  always_comb begin
    valid_o = 1'b1;
    cause_o = '0;
    if (exc_hit_i) begin
      cause_o[CODE_W-1:0] = exc_code_i;
    end else if (irq_live[LVL_SUP]) begin
      cause_o[XLEN-1] = 1'b1;
      cause_o[CODE_W-1:0] = CODE_W'(LVL_SUP);
    end else if (irq_live[LVL_USR]) begin
      cause_o[XLEN-1] = 1'b1;
      cause_o[CODE_W-1:0] = CODE_W'(LVL_USR);
    end else begin
      valid_o = 1'b0;
    end
  end
endmodule

// File: rtl/swi_trap_unit.sv
module swi_trap_unit
  import swi_trap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_we_i,
  input  logic               csr_wsel_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  input  logic               csr_rsel_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  input  logic [NUM_EXC-1:0] exc_i,
  input  logic               ecall_i,
  input  logic [1:0]         priv_i,
  input  logic               gie_i,
  output logic               trap_valid_o,
  output logic [XLEN-1:0]    trap_cause_o
);
  logic [NUM_LVL-1:0] pend_q, en_q;
  logic               exc_hit;
  logic [CODE_W-1:0]  exc_code;

  swi_csr_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i),
    .wsel_i  (csr_wsel_i),
    .wdata_i (csr_wdata_i),
    .rsel_i  (csr_rsel_i),
    .pend_o  (pend_q),
    .en_o    (en_q),
    .rdata_o (csr_rdata_o)
  );

  swi_exc_pick u_pick (
    .exc_i   (exc_i),
    .ecall_i (ecall_i),
    .priv_i  (priv_i),
    .hit_o   (exc_hit),
    .code_o  (exc_code)
  );

  swi_trap_arb u_arb (
    .exc_hit_i  (exc_hit),
    .exc_code_i (exc_code),
    .pend_i     (pend_q),
    .en_i       (en_q),
    .gie_i      (gie_i),
    .valid_o    (trap_valid_o),
    .cause_o    (trap_cause_o)
  );
endmodule

// File: rtl/swi_trap_chk.sv
module swi_trap_chk
  import swi_trap_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               csr_we_i,
  input logic               csr_wsel_i,
  input logic [NUM_EXC-1:0] exc_i,
  input logic               ecall_i,
  input logic               gie_i,
  input logic [NUM_LVL-1:0] pend_q,
  input logic [NUM_LVL-1:0] en_q,
  input logic               trap_valid_o,
  input logic [XLEN-1:0]    trap_cause_o
);
  logic any_exc;
  assign any_exc = (|(exc_i & EXC_MASK)) || ecall_i;

  a_r9_exc_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_exc |-> (trap_valid_o && !trap_cause_o[XLEN-1]));

  a_r6_gie_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_exc && !gie_i) |-> !trap_valid_o);

  a_r4_sup_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_exc && gie_i && pend_q[LVL_SUP] && en_q[LVL_SUP])
      |-> (trap_valid_o && trap_cause_o == 32'h8000_0001));

  a_r5_usr_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_exc && gie_i && !(pend_q[LVL_SUP] && en_q[LVL_SUP])
      && pend_q[LVL_USR] && en_q[LVL_USR])
      |-> (trap_valid_o && trap_cause_o == 32'h8000_0000));

  a_r10_pend_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_we_i && csr_wsel_i == SEL_PEND) |=> $stable(pend_q));
endmodule

bind swi_trap_unit swi_trap_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .csr_we_i     (csr_we_i),
  .csr_wsel_i   (csr_wsel_i),
  .exc_i        (exc_i),
  .ecall_i      (ecall_i),
  .gie_i        (gie_i),
  .pend_q       (pend_q),
  .en_q         (en_q),
  .trap_valid_o (trap_valid_o),
  .trap_cause_o (trap_cause_o)
);

// File: tb/sim_swi_trap_unit.sv
module sim_swi_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, wsel = 1'b0, rsel = 1'b0, ecall = 1'b0, gie = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  exc = '0;
  logic [1:0]  priv = '0;
  logic [31:0] rdata, cause;
  logic        valid;

  logic [1:0]  m_pend = '0, m_en = '0;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  swi_trap_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_wsel_i(wsel),
    .csr_wdata_i(wdata), .csr_rsel_i(rsel), .csr_rdata_o(rdata),
    .exc_i(exc), .ecall_i(ecall), .priv_i(priv), .gie_i(gie),
    .trap_valid_o(valid), .trap_cause_o(cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [32:0] exp_trap(input logic [7:0] ex, input logic ec,
                                          input logic [1:0] pr, input logic g,
                                          input logic [1:0] p, input logic [1:0] e);
    logic [7:0] live;
    live = ex & 8'hAF;
    for (int i = 0; i < 8; i++) if (live[i]) return {1'b1, 32'(i)};
    if (ec) return {1'b1, 32'(8 + pr)};
    if (g && p[1] && e[1]) return {1'b1, 32'h8000_0001};
    if (g && p[0] && e[0]) return {1'b1, 32'h8000_0000};
    return 33'd0;
  endfunction

  task automatic step(input logic w, input logic ws, input logic [31:0] wd,
                      input logic rs, input logic [7:0] ex, input logic ec,
                      input logic [1:0] pr, input logic g);
    logic [32:0] e;
    string tag;
    @(negedge clk);
    we = w; wsel = ws; wdata = wd; rsel = rs; exc = ex; ecall = ec; priv = pr; gie = g;
    #1;
    e = exp_trap(ex, ec, pr, g, m_pend, m_en);
    if ((ex & 8'hAF) != 0) tag = "R7";
    else if (ec) tag = "R8";
    else if (g && ((m_pend & m_en) != 0)) tag = (m_pend[1] && m_en[1]) ? "R4" : "R5";
    else tag = "R6";
    if (e[32] && !e[31] && g && ((m_pend & m_en) != 0)) tag = "R9";
    chk({tag, " valid"}, {31'd0, valid}, {31'd0, e[32]});
    if (e[32]) chk({tag, " cause"}, cause, e[31:0]);
    chk(rs ? "R3 read" : "R2 read", rdata, {30'd0, rs ? m_en : m_pend});
    @(posedge clk);
    if (w) begin
      if (ws) m_en = wd[1:0];
      else    m_pend = wd[1:0];
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    // R1: reset state
    #3;
    rsel = 0; #1; chk("R1 pend", rdata, 32'd0);
    rsel = 1; #1; chk("R1 en", rdata, 32'd0);
    chk("R1 valid", {31'd0, valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 1);
    // R2/R3 upper bits ignored on write
    step(1, 0, 32'hFFFF_FFFE, 0, 0, 0, 0, 0);
    step(1, 1, 32'hFFFF_FFFD, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    // R6: pending but enable off / gie off
    step(1, 1, 32'h0, 0, 0, 0, 0, 1);
    step(1, 1, 32'h3, 1, 0, 0, 0, 0);
    step(1, 0, 32'h3, 0, 0, 0, 0, 0);
    // R5 loses to R4, then user alone
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 0, 32'h1, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 0, 32'h3, 0, 0, 0, 0, 1);
    // R10: traps taken repeatedly, pending kept
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 0, 0, 1);
    // R11: clear in the trap cycle, old value seen, new next cycle
    step(1, 0, 32'h0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 0, 32'h3, 0, 0, 0, 0, 1);
    // R7: masked codes 4 and 6 ignored; lowest wins; R9 over live irq
    step(0, 0, 0, 0, 8'h50, 0, 0, 0);
    step(0, 0, 0, 0, 8'h50, 0, 0, 1);
    step(0, 0, 0, 0, 8'hA0, 1, 3, 1);
    step(0, 0, 0, 0, 8'h88, 0, 0, 1);
    // R8: each privilege
    for (int p = 0; p < 4; p++) step(0, 0, 0, 0, 0, 1, 2'(p), 1);
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ex;
      ex = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
      step(1'($urandom % 3 == 0), 1'($urandom), $urandom, 1'($urandom), ex,
           1'($urandom % 6 == 0), 2'($urandom), 1'($urandom % 4 != 0));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule